// File: doc/BRIEF.md
# Region-Based Memory Access Mapper

This block sits between a fast CPU with a 24-bit address bus and the memory paths behind it. For every CPU access it produces one registered set of strobes. These strobes pick local fast RAM, a request to the slow host bus, both, or the mapper's own register window.

The lower 64 KB is split into four 16 KB windows, and each window has its own routing policy. Writes can be mirrored into fast RAM while the host memory stays current. Reads can then be served from fast RAM without the slow bus cycle. In window 0 only, fast RAM can also take over completely. Addresses above the first 64 KB go straight to fast RAM.

An optional wrap maps the first 256 bytes of bank 1 back onto the zero page while the CPU runs in emulation mode. The register window in the I/O page stays hidden until a gate register is unlocked.

Top module: `amap_top`

## Requirements
- R1: Synchronous reset clears all output strobes, sets every window to the no-speed-up policy, turns off wrap and the cartridge option, and hides the register window. After reset, 0xD100 reads go to the host bus and 0x010005 reads go to fast RAM unwrapped.
- R2: In no-speed-up mode (mode code 0), a write asserts both `fram_wr` and `host_wr` at the same address, and a read asserts only `host_rd`.
- R3: In fast-read mode (mode code 1), a write asserts both `fram_wr` and `host_wr`, and a read asserts only `fram_rd`.
- R4: Fast read/write mode (code 2) sends reads and writes to fast RAM only, and only in window 0. Code 2 in any other window, and code 3 anywhere, behave as code 1.
- R5: When the cartridge option (option register bit 1) is set, window 2 (0x8000–0xBFFF) uses no-speed-up mode whatever its mode field holds. The other windows are unaffected.
- R6: When wrap (option register bit 0) is set and `cpu_emu` is high, addresses 0x010000–0x0100FF are routed as 0x000000–0x0000FF under window 0's policy. Without `cpu_emu`, or outside that range, bank 1 is not remapped.
- R7: Addresses at or above 0x010000 that are not wrapped assert only the fast RAM strobe for their direction, with the unchanged address, and never a host strobe.
- R8: While the window is hidden, only an access whose low 16 bits equal 0xD1FF exactly in bank 0 reaches the register strobes. Other 0xD1xx accesses go to the host bus, and writes to them leave the configuration unchanged. The same offset in bank 1 is ordinary fast memory.
- R9: Writing 0x01 to 0xD1FF exposes the whole 0xD100–0xD1FF page as register strobes. Writing any other value hides it again. Once exposed, offset 0xF0 holds the window mode fields, two bits per window with window n in bits [2n+1:2n], and offset 0xF1 holds the options.
- R10: Bank-0 accesses to the host I/O range 0xD000–0xD7FF that the register window does not claim go to the host bus only, whatever window 3's mode is.
- R11: Outputs appear one clock after the access is presented. A cycle without `cpu_valid` yields no strobes. A register strobe never coincides with a fast RAM or host strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | An access is presented this cycle |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_emu | input | 1 | CPU is in emulation mode |
| cpu_addr | input | 24 | CPU byte address |
| cpu_wdata | input | 8 | Write data |
| fram_rd | output | 1 | Fast RAM read strobe |
| fram_wr | output | 1 | Fast RAM write strobe |
| fram_addr | output | 24 | Fast RAM address after wrap |
| host_rd | output | 1 | Slow host bus read request |
| host_wr | output | 1 | Slow host bus write request |
| host_addr | output | 16 | Host bus address after wrap |
| reg_rd | output | 1 | Register window read strobe |
| reg_wr | output | 1 | Register window write strobe |
| reg_idx | output | 8 | Register offset within the I/O page |
| out_wdata | output | 8 | Write data registered alongside the strobes |

## Verification
The assertions assume that `cpu_addr`, `cpu_rd` and `cpu_emu` are stable and meaningful whenever `cpu_valid` is high. They also assume that a single cycle carries at most one access, so each strobe set maps to the access of the previous cycle. The stimulus changes inputs only on the falling edge and presents each access for exactly one rising edge, then drops `cpu_valid` before the next one. Register writes that change the configuration are issued as separate accesses, so the following access always sees the settled configuration.

// File: rtl/amap_pkg.sv
package amap_pkg;

  localparam int MODE_W = 2;

  // Per-window routing policy codes
  typedef enum logic [MODE_W-1:0] {
    MODE_SLOW = 2'd0,  // writes mirrored, reads from host
    MODE_FRD  = 2'd1,  // writes mirrored, reads from fast RAM
    MODE_FRW  = 2'd2,  // fast RAM only (window 0)
    MODE_RSV  = 2'd3   // treated as fast read
  } rmode_t;

  typedef struct packed {
    logic fram_rd;
    logic fram_wr;
    logic host_rd;
    logic host_wr;
    logic reg_rd;
    logic reg_wr;
  } route_t;

endpackage

// File: rtl/amap_cfg.sv
module amap_cfg
  import amap_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int REGION_CNT = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         gate_wr,
  input  logic                         mode_wr,
  input  logic                         opt_wr,
  input  logic [DATA_W-1:0]            wdata,
  output logic                         regs_on,
  output logic [REGION_CNT*MODE_W-1:0] mode_raw,
  output logic                         wrap_on,
  output logic                         cart_on
);

  localparam int MODE_BITS = REGION_CNT * MODE_W;
  localparam logic [DATA_W-1:0] UNLOCK = DATA_W'(1);

  logic [MODE_BITS-1:0] mode_q;
  logic                 gate_q;
  logic [1:0]           opt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      mode_q <= '0;
      opt_q  <= '0;
    end else begin
      if (gate_wr) gate_q <= (wdata == UNLOCK);
      if (mode_wr) mode_q <= wdata[MODE_BITS-1:0];
      if (opt_wr)  opt_q  <= wdata[1:0];
    end
  end

  assign regs_on  = gate_q;
  assign mode_raw = mode_q;
  assign wrap_on  = opt_q[0];
  assign cart_on  = opt_q[1];

endmodule

// File: rtl/amap_policy.sv
module amap_policy
  import amap_pkg::*;
#(
  parameter int REGION_CNT  = 4,
  parameter int CART_REGION = 2
) (
  input  logic [REGION_CNT*MODE_W-1:0] mode_raw,
  input  logic                         cart_on,
  output logic [REGION_CNT*MODE_W-1:0] eff_mode
);

  for (genvar g = 0; g < REGION_CNT; g++) begin : g_win
    logic [MODE_W-1:0] raw;
    logic [MODE_W-1:0] eff;

    assign raw = mode_raw[g*MODE_W +: MODE_W];

    always_comb begin
      if (cart_on && (g == CART_REGION)) begin
        eff = MODE_SLOW;
      end else if (raw == MODE_RSV) begin
        eff = MODE_FRD;
      end else if ((raw == MODE_FRW) && (g != 0)) begin
        eff = MODE_FRD;
      end else begin
        eff = raw;
      end
    end

    assign eff_mode[g*MODE_W +: MODE_W] = eff;
  end

endmodule

// File: rtl/amap_decode.sv
module amap_decode
  import amap_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          LOW_W      = 16,
  parameter int          REGION_CNT = 4,
  parameter logic [7:0]  IO_PAGE    = 8'hD1,
  parameter logic [7:0]  GATE_LO    = 8'hFF,
  parameter logic [7:0]  HOSTIO_LO  = 8'hD0,
  parameter logic [7:0]  HOSTIO_HI  = 8'hD7,
  parameter int          WRAP_BANK  = 1
) (
  input  logic                         valid,
  input  logic                         rd,
  input  logic                         emu,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [REGION_CNT*MODE_W-1:0] eff_mode,
  input  logic                         regs_on,
  input  logic                         wrap_on,
  output route_t                       route,
  output logic [ADDR_W-1:0]            eff_addr
);

  localparam int BANK_W = ADDR_W - LOW_W;
  localparam int RIDX_W = $clog2(REGION_CNT);
  localparam logic [BANK_W-1:0] WRAP_B = BANK_W'(WRAP_BANK);

  logic [BANK_W-1:0] bank;
  logic [7:0]        page;
  logic              bank0, wrap_hit, in_low, io_page, reg_hit, host_io;
  logic [RIDX_W-1:0] ridx;
  logic [MODE_W-1:0] wmode;

  assign bank     = addr[ADDR_W-1:LOW_W];
  assign page     = addr[LOW_W-1:LOW_W-8];
  assign bank0    = (bank == '0);
  assign wrap_hit = wrap_on && emu && (bank == WRAP_B) && (page == 8'h00);
  assign in_low   = bank0 || wrap_hit;
  assign eff_addr = wrap_hit ? {{(ADDR_W-8){1'b0}}, addr[7:0]} : addr;

  assign io_page  = bank0 && (page == IO_PAGE);
  assign reg_hit  = io_page && (regs_on || (addr[7:0] == GATE_LO));
  assign host_io  = bank0 && (page >= HOSTIO_LO) && (page <= HOSTIO_HI);

  assign ridx     = eff_addr[LOW_W-1 -: RIDX_W];
  assign wmode    = eff_mode[ridx*MODE_W +: MODE_W];

  always_comb begin
    route = '0;
    if (valid) begin
      if (reg_hit) begin
        route.reg_rd = rd;
        route.reg_wr = !rd;
      end else if (!in_low) begin
        route.fram_rd = rd;
        route.fram_wr = !rd;
      end else if (host_io) begin
        route.host_rd = rd;
        route.host_wr = !rd;
      end else begin
        unique case (wmode)
          MODE_FRW: begin
            route.fram_rd = rd;
            route.fram_wr = !rd;
          end
          MODE_FRD: begin
            route.fram_rd = rd;
            route.fram_wr = !rd;
            route.host_wr = !rd;
          end
          default: begin
            route.host_rd = rd;
            route.fram_wr = !rd;
            route.host_wr = !rd;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/amap_top.sv
module amap_top
  import amap_pkg::*;
#(
  parameter int         ADDR_W      = 24,
  parameter int         DATA_W      = 8,
  parameter int         LOW_W       = 16,
  parameter int         REGION_CNT  = 4,
  parameter int         CART_REGION = 2,
  parameter logic [7:0] IO_PAGE     = 8'hD1,
  parameter logic [7:0] GATE_LO     = 8'hFF,
  parameter logic [7:0] MODE_LO     = 8'hF0,
  parameter logic [7:0] OPT_LO      = 8'hF1,
  parameter logic [7:0] HOSTIO_LO   = 8'hD0,
  parameter logic [7:0] HOSTIO_HI   = 8'hD7,
  parameter int         WRAP_BANK   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_rd,
  input  logic              cpu_emu,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              fram_rd,
  output logic              fram_wr,
  output logic [ADDR_W-1:0] fram_addr,
  output logic              host_rd,
  output logic              host_wr,
  output logic [LOW_W-1:0]  host_addr,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [7:0]        reg_idx,
  output logic [DATA_W-1:0] out_wdata
);

  localparam int MODE_BITS = REGION_CNT * MODE_W;

  logic [MODE_BITS-1:0] mode_raw, eff_mode;
  logic                 regs_on, wrap_on, cart_on;
  logic                 gate_wr, mode_wr, opt_wr;
  route_t               route_d, route_q;
  logic [ADDR_W-1:0]    eff_addr;

  assign gate_wr = route_d.reg_wr && (cpu_addr[7:0] == GATE_LO);
  assign mode_wr = route_d.reg_wr && (cpu_addr[7:0] == MODE_LO);
  assign opt_wr  = route_d.reg_wr && (cpu_addr[7:0] == OPT_LO);

  amap_cfg #(
    .DATA_W(DATA_W), .REGION_CNT(REGION_CNT)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .gate_wr(gate_wr), .mode_wr(mode_wr), .opt_wr(opt_wr),
    .wdata(cpu_wdata),
    .regs_on(regs_on), .mode_raw(mode_raw),
    .wrap_on(wrap_on), .cart_on(cart_on)
  );

  amap_policy #(
    .REGION_CNT(REGION_CNT), .CART_REGION(CART_REGION)
  ) u_policy (
    .mode_raw(mode_raw), .cart_on(cart_on), .eff_mode(eff_mode)
  );

  amap_decode #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .REGION_CNT(REGION_CNT),
    .IO_PAGE(IO_PAGE), .GATE_LO(GATE_LO),
    .HOSTIO_LO(HOSTIO_LO), .HOSTIO_HI(HOSTIO_HI), .WRAP_BANK(WRAP_BANK)
  ) u_decode (
    .valid(cpu_valid), .rd(cpu_rd), .emu(cpu_emu), .addr(cpu_addr),
    .eff_mode(eff_mode), .regs_on(regs_on), .wrap_on(wrap_on),
    .route(route_d), .eff_addr(eff_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q   <= '0;
      fram_addr <= '0;
      host_addr <= '0;
      reg_idx   <= '0;
      out_wdata <= '0;
    end else begin
      route_q   <= route_d;
      fram_addr <= eff_addr;
      host_addr <= eff_addr[LOW_W-1:0];
      reg_idx   <= cpu_addr[7:0];
      out_wdata <= cpu_wdata;
    end
  end

  assign fram_rd = route_q.fram_rd;
  assign fram_wr = route_q.fram_wr;
  assign host_rd = route_q.host_rd;
  assign host_wr = route_q.host_wr;
  assign reg_rd  = route_q.reg_rd;
  assign reg_wr  = route_q.reg_wr;

endmodule

// File: rtl/amap_checker.sv
module amap_checker #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_rd,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              fram_rd,
  input logic              fram_wr,
  input logic              host_rd,
  input logic              host_wr,
  input logic              reg_rd,
  input logic              reg_wr
);

  localparam int BANK_W = ADDR_W - LOW_W;

  logic any_strobe, mem_strobe, bank0, bank_high, io_other;

  assign mem_strobe = fram_rd || fram_wr || host_rd || host_wr;
  assign any_strobe = mem_strobe || reg_rd || reg_wr;
  assign bank0      = (cpu_addr[ADDR_W-1:LOW_W] == '0);
  assign bank_high  = (cpu_addr[ADDR_W-1:LOW_W] > BANK_W'(1));
  assign io_other   = bank0 && (cpu_addr[LOW_W-1:LOW_W-8] >= 8'hD0)
                      && (cpu_addr[LOW_W-1:LOW_W-8] <= 8'hD7)
                      && (cpu_addr[LOW_W-1:LOW_W-8] != 8'hD1);

  // R1: reset leaves no strobe behind
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !any_strobe);

  // R11: idle cycle yields no strobe on the next
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |=> !any_strobe);

  // R11: register strobes exclusive with memory strobes
  a_r11_reg_exclusive: assert property (@(posedge clk) disable iff (rst)
    (reg_rd || reg_wr) |-> !mem_strobe);

  // R7: high banks never reach the host bus
  a_r7_high_no_host: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && bank_high) |=> (!host_rd && !host_wr));

  // R2: a read has exactly one data source
  a_r2_single_source: assert property (@(posedge clk) disable iff (rst)
    !(fram_rd && host_rd));

  // R10: unclaimed host I/O reads go to the host only
  a_r10_hostio_read: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_rd && io_other) |=> (host_rd && !fram_rd));

  // R8: the gate register always answers in bank 0
  a_r8_gate_visible: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && bank0 && (cpu_addr[LOW_W-1:0] == 16'hD1FF)) |=> (reg_rd || reg_wr));

endmodule

bind amap_top amap_checker #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_amap_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_rd(cpu_rd),
  .cpu_addr(cpu_addr), .fram_rd(fram_rd), .fram_wr(fram_wr),
  .host_rd(host_rd), .host_wr(host_wr), .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/test_amap_top.sv
module test_amap_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0;
  logic        cpu_rd = 1'b1;
  logic        cpu_emu = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        fram_rd, fram_wr, host_rd, host_wr, reg_rd, reg_wr;
  logic [23:0] fram_addr;
  logic [15:0] host_addr;
  logic [7:0]  reg_idx, out_wdata;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amap_top i_amap_top (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_rd(cpu_rd),
    .cpu_emu(cpu_emu), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .fram_rd(fram_rd), .fram_wr(fram_wr), .fram_addr(fram_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx), .out_wdata(out_wdata)
  );

  // Flags order: {fram_rd, fram_wr, host_rd, host_wr, reg_rd, reg_wr}
  // Vector: {addr[24], rd, emu, flags[6], expected address[24], req[4]}
  // Default configuration, register window hidden. Writes carry 0xAA.
  localparam logic [59:0] VEC [NVEC] = '{
    {24'h001234, 1'b1, 1'b0, 6'b001000, 24'h001234, 4'd2},  // R2 read
    {24'h001234, 1'b0, 1'b0, 6'b010100, 24'h001234, 4'd2},  // R2 write
    {24'h008000, 1'b1, 1'b0, 6'b001000, 24'h008000, 4'd2},  // R2 window 2
    {24'h020000, 1'b1, 1'b0, 6'b100000, 24'h020000, 4'd7},  // R7 read
    {24'h020000, 1'b0, 1'b0, 6'b010000, 24'h020000, 4'd7},  // R7 write
    {24'h010010, 1'b1, 1'b1, 6'b100000, 24'h010010, 4'd6},  // R6 wrap off
    {24'h00D1FF, 1'b1, 1'b0, 6'b000010, 24'h0000FF, 4'd8},  // R8 gate visible
    {24'h00D1F0, 1'b0, 1'b0, 6'b000100, 24'h00D1F0, 4'd8},  // R8 hidden write
    {24'h00D40A, 1'b1, 1'b0, 6'b001000, 24'h00D40A, 4'd10}, // R10 host I/O
    {24'h01D1FF, 1'b1, 1'b0, 6'b100000, 24'h01D1FF, 4'd8},  // R8 bank 1
    {24'h000200, 1'b1, 1'b0, 6'b001000, 24'h000200, 4'd8}   // R8 modes kept
  };

  task automatic check(input logic [5:0] exp, input logic [23:0] ea, input string req);
    logic [5:0] act;
    act = {fram_rd, fram_wr, host_rd, host_wr, reg_rd, reg_wr};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s strobes act=%b exp=%b", req, act, exp);
    end else if ((fram_rd || fram_wr) && fram_addr !== ea) begin
      n_fail++;
      $display("FAIL %s fram_addr act=%h exp=%h", req, fram_addr, ea);
    end else if ((host_rd || host_wr) && host_addr !== ea[15:0]) begin
      n_fail++;
      $display("FAIL %s host_addr act=%h exp=%h", req, host_addr, ea[15:0]);
    end else if ((reg_rd || reg_wr) && reg_idx !== ea[7:0]) begin
      n_fail++;
      $display("FAIL %s reg_idx act=%h exp=%h", req, reg_idx, ea[7:0]);
    end
  endtask

  task automatic run(input logic [23:0] a, input logic rd, input logic emu,
                     input logic [7:0] wd, input logic [5:0] exp,
                     input logic [23:0] ea, input string req);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_rd = rd; cpu_emu = emu; cpu_wdata = wd;
    @(posedge clk); #1;
    check(exp, ea, req);
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check(6'b000000, 24'h0, "R1");
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();  // R1

    for (int i = 0; i < NVEC; i++) begin
      run(VEC[i][59:36], VEC[i][35], VEC[i][34], 8'hAA, VEC[i][33:28],
          VEC[i][27:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    // R9: unlock, then program modes {w3=01, w2=01, w1=10, w0=10}
    run(24'h00D1FF, 1'b0, 1'b0, 8'h01, 6'b000001, 24'h0000FF, "R9");
    run(24'h00D1F0, 1'b0, 1'b0, 8'h5A, 6'b000001, 24'h0000F0, "R9");
    // R4: window 0 fast read/write
    run(24'h000100, 1'b1, 1'b0, 8'h00, 6'b100000, 24'h000100, "R4");
    run(24'h000100, 1'b0, 1'b0, 8'hAA, 6'b010000, 24'h000100, "R4");
    // R4: code 2 in window 1 acts as fast read
    run(24'h004000, 1'b1, 1'b0, 8'h00, 6'b100000, 24'h004000, "R4");
    // R3: fast-read write is mirrored
    run(24'h004000, 1'b0, 1'b0, 8'h55, 6'b010100, 24'h004000, "R3");
    run(24'h008000, 1'b1, 1'b0, 8'h00, 6'b100000, 24'h008000, "R3");
    // R5: cartridge option forces window 2 slow
    run(24'h00D1F1, 1'b0, 1'b0, 8'h02, 6'b000001, 24'h0000F1, "R5");
    run(24'h008000, 1'b1, 1'b0, 8'h00, 6'b001000, 24'h008000, "R5");
    run(24'h004000, 1'b1, 1'b0, 8'h00, 6'b100000, 24'h004000, "R5");
    // R6: wrap on, cartridge off
    run(24'h00D1F1, 1'b0, 1'b0, 8'h01, 6'b000001, 24'h0000F1, "R6");
    run(24'h010005, 1'b1, 1'b1, 8'h00, 6'b100000, 24'h000005, "R6");
    run(24'h010005, 1'b1, 1'b0, 8'h00, 6'b100000, 24'h010005, "R6");
    run(24'h010105, 1'b1, 1'b1, 8'h00, 6'b100000, 24'h010105, "R6");
    // R10: host I/O range stays on host with window 3 in fast read
    run(24'h00D40A, 1'b1, 1'b0, 8'h00, 6'b001000, 24'h00D40A, "R10");
    run(24'h00D40A, 1'b0, 1'b0, 8'h33, 6'b000100, 24'h00D40A, "R10");
    // R9: whole page visible
    run(24'h00D100, 1'b1, 1'b0, 8'h00, 6'b000010, 24'h000000, "R9");
    // R6: wrapped access under slow window 0
    run(24'h00D1F0, 1'b0, 1'b0, 8'h00, 6'b000001, 24'h0000F0, "R9");
    run(24'h010007, 1'b1, 1'b1, 8'h00, 6'b001000, 24'h000007, "R6");
    // R9: other value hides; R8: hidden write ignored
    run(24'h00D1FF, 1'b0, 1'b0, 8'h03, 6'b000001, 24'h0000FF, "R9");
    run(24'h00D1F0, 1'b0, 1'b0, 8'h5A, 6'b000100, 24'h00D1F0, "R8");
    run(24'h000100, 1'b1, 1'b0, 8'h00, 6'b001000, 24'h000100, "R8");
    run(24'h00D1FF, 1'b1, 1'b0, 8'h00, 6'b000010, 24'h0000FF, "R8");

    // R11: no access, no strobe
    @(posedge clk); #1;
    check(6'b000000, 24'h0, "R11");

    // R1: reset re-hides window and clears modes and wrap
    run(24'h00D1FF, 1'b0, 1'b0, 8'h01, 6'b000001, 24'h0000FF, "R9");
    run(24'h00D1F0, 1'b0, 1'b0, 8'h5A, 6'b000001, 24'h0000F0, "R9");
    run(24'h00D1F1, 1'b0, 1'b0, 8'h01, 6'b000001, 24'h0000F1, "R9");
    do_reset();
    run(24'h000100, 1'b1, 1'b0, 8'h00, 6'b001000, 24'h000100, "R1");
    run(24'h00D100, 1'b1, 1'b0, 8'h00, 6'b001000, 24'h00D100, "R1");
    run(24'h010005, 1'b1, 1'b1, 8'h00, 6'b100000, 24'h010005, "R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule